// File: doc/BRIEF.md
# Priority Interrupt Level Selector

This block turns a set of level-sensitive interrupt sources into one processor interrupt request. Fifteen external lines and a software interrupt register form a single pending mask of sixteen levels. The register's two timer-match bits do not map to levels of their own. Either one being set raises level 14. The block then looks only at the pending levels that lie strictly above the processor's current priority level and picks the highest of them. It latches a trap code made from the external-interrupt trap base (0x40) ORed with that level number, and raises its request line.

Several conditions override the selection. While a vector interrupt is being delivered, the block freezes its outputs. When interrupts are globally disabled, or no pending level is eligible, the request is withdrawn and the code returns to zero. When the processor is already handling an external-interrupt-class trap whose code is higher than the new candidate, the candidate is held back. A new code is loaded only when it differs from the code already latched. All outputs are registered, so each decision takes effect one clock after the inputs that caused it.

Top module: `irq_level_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `irq_req` is 0 and `irq_code` is 0.
- R2: External line `ext_lvl[L-1]` and soft register bit `soft_reg[L]` each make level L (1 to 15) pending. Both sources produce the same trap code.
- R3: Soft bit 0 or soft bit 16 (the timer-match bits) makes level 14 pending, which gives code 0x04E. Neither bit makes a level of its own number pending.
- R4: Only pending levels strictly greater than `cur_pil` are eligible. With none eligible, the request drops and the code becomes 0. With `cur_pil` = 15, no request is ever made.
- R5: The highest eligible level wins. The code is 0x040 ORed with the level number, so bits [8:4] of an active code always read 0x04.
- R6: While `vec_busy` is 1, `irq_req` and `irq_code` keep their values whatever the other inputs do.
- R7: When `glb_ie` is 0 and `vec_busy` is 0, the request drops and the code becomes 0.
- R8: If `trap_lvl` is non-zero, `tt_active` bits [8:4] equal 0x04, and `tt_active` is greater than the new code, the outputs keep their previous values. If `trap_lvl` is 0, or the class differs, or `tt_active` is not greater, the new code is loaded.
- R9: Outputs change one clock edge after the inputs that cause the change, and not before.
- R10: `irq_req` is 1 exactly when `irq_code` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_lvl | input | 15 | External level requests; bit i is level i+1 |
| soft_reg | input | 17 | Software interrupt register; bits 0 and 16 are timer-match |
| cur_pil | input | 4 | Current processor priority level |
| glb_ie | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| tt_active | input | 9 | Trap code currently in service |
| vec_busy | input | 1 | Vector interrupt delivery in progress |
| irq_req | output | 1 | Hardware interrupt request |
| irq_code | output | 9 | Selected trap code (0 when idle) |

## Verification
The bench builds the block with its defaults: sixteen levels, a 17-bit soft register with timer bits at 0 and 16, timer level 14, and a 9-bit code with base 0x040. With these values the top-level edge is reachable, where a priority of 15 shuts out every level. Both timer-bit positions can be shown to fold into level 14. The nesting rule can be tested on each of its three escape conditions: trap level zero, a foreign trap class, and a lower in-service code.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
   localparam int unsigned DEF_LEVELS    = 16;
   localparam int unsigned DEF_SOFT_W    = 17;
   localparam int unsigned DEF_CODE_W    = 9;
   localparam int unsigned DEF_TL_W      = 3;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_LOAD  = 2'd2
   } lvl_act_e;
endpackage

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
   parameter int unsigned LEVELS      = 16,
   parameter int unsigned SOFT_W      = 17,
   parameter int unsigned TMR_A_BIT   = 0,
   parameter int unsigned TMR_B_BIT   = 16,
   parameter int unsigned TIMER_LEVEL = 14
) (
   input  logic [LEVELS-2:0] ext_lvl,
   input  logic [SOFT_W-1:0] soft_reg,
   output logic [LEVELS-1:0] pend
);
   logic timer_any;
   assign timer_any = soft_reg[TMR_A_BIT] | soft_reg[TMR_B_BIT];

   for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
      localparam bit IS_TMR = (j == TMR_A_BIT) || (j == TMR_B_BIT);
      logic from_ext, from_soft, from_tmr;

      if (j == 0) begin : g_ext0
         assign from_ext = 1'b0;
      end else begin : g_extn
         assign from_ext = ext_lvl[j-1];
      end

      if ((j < SOFT_W) && !IS_TMR) begin : g_soft
         assign from_soft = soft_reg[j];
      end else begin : g_nosoft
         assign from_soft = 1'b0;
      end

      if (j == TIMER_LEVEL) begin : g_tmr
         assign from_tmr = timer_any;
      end else begin : g_notmr
         assign from_tmr = 1'b0;
      end

      assign pend[j] = from_ext | from_soft | from_tmr;
   end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
   parameter int unsigned LEVELS = 16,
   localparam int unsigned LVL_W = $clog2(LEVELS)
) (
   input  logic [LEVELS-1:0] pend,
   input  logic [LVL_W-1:0]  cur_pil,
   output logic              hit,
   output logic [LVL_W-1:0]  win_lvl
);
   logic [LEVELS-1:0] elig;

   for (genvar j = 0; j < LEVELS; j++) begin : g_elig
      localparam logic [LVL_W-1:0] LV = LVL_W'(j);
      assign elig[j] = pend[j] & (LV > cur_pil);
   end

   assign hit = |elig;

   always_comb begin
      win_lvl = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (elig[k]) win_lvl = LVL_W'(k);
      end
   end
endmodule

// File: rtl/irq_nest_guard.sv
module irq_nest_guard #(
   parameter int unsigned CODE_W     = 9,
   parameter int unsigned TL_W       = 3,
   parameter logic [CODE_W-1:0] TRAP_BASE  = 9'h040,
   parameter logic [CODE_W-1:0] CLASS_MASK = 9'h1F0
) (
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [CODE_W-1:0] tt_active,
   input  logic [CODE_W-1:0] new_code,
   output logic              blocked
);
   logic nested, same_class, outranks;
   assign nested     = |trap_lvl;
   assign same_class = (tt_active & CLASS_MASK) == TRAP_BASE;
   assign outranks   = tt_active > new_code;
   assign blocked    = nested & same_class & outranks;
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
   import irq_lvl_pkg::*;
#(
   parameter int unsigned LEVELS      = DEF_LEVELS,
   parameter int unsigned SOFT_W      = DEF_SOFT_W,
   parameter int unsigned TMR_A_BIT   = 0,
   parameter int unsigned TMR_B_BIT   = 16,
   parameter int unsigned TIMER_LEVEL = 14,
   parameter int unsigned CODE_W      = DEF_CODE_W,
   parameter int unsigned TL_W        = DEF_TL_W,
   parameter logic [CODE_W-1:0] TRAP_BASE  = 9'h040,
   parameter logic [CODE_W-1:0] CLASS_MASK = 9'h1F0,
   localparam int unsigned LVL_W = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEVELS-2:0] ext_lvl,
   input  logic [SOFT_W-1:0] soft_reg,
   input  logic [LVL_W-1:0]  cur_pil,
   input  logic              glb_ie,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [CODE_W-1:0] tt_active,
   input  logic              vec_busy,
   output logic              irq_req,
   output logic [CODE_W-1:0] irq_code
);
   if (LEVELS < 2 || (LEVELS & (LEVELS - 1)) != 0) begin : g_chk_lv
      $error("LEVELS must be a power of two of at least 2");
   end
   if (TIMER_LEVEL >= LEVELS || TMR_A_BIT >= SOFT_W || TMR_B_BIT >= SOFT_W) begin : g_chk_tmr
      $error("timer bit or timer level out of range");
   end
   if (CODE_W <= LVL_W || (TRAP_BASE & CODE_W'(LEVELS - 1)) != 0) begin : g_chk_code
      $error("trap base must leave the level field clear");
   end

   logic [LEVELS-1:0] pend;
   logic              hit;
   logic [LVL_W-1:0]  win_lvl;
   logic [CODE_W-1:0] new_code;
   logic              blocked;
   lvl_act_e          act;

   irq_pend_merge #(
      .LEVELS(LEVELS), .SOFT_W(SOFT_W), .TMR_A_BIT(TMR_A_BIT),
      .TMR_B_BIT(TMR_B_BIT), .TIMER_LEVEL(TIMER_LEVEL)
   ) u_merge (
      .ext_lvl(ext_lvl), .soft_reg(soft_reg), .pend(pend)
   );

   irq_level_pick #(.LEVELS(LEVELS)) u_pick (
      .pend(pend), .cur_pil(cur_pil), .hit(hit), .win_lvl(win_lvl)
   );

   assign new_code = TRAP_BASE | CODE_W'(win_lvl);

   irq_nest_guard #(
      .CODE_W(CODE_W), .TL_W(TL_W), .TRAP_BASE(TRAP_BASE), .CLASS_MASK(CLASS_MASK)
   ) u_guard (
      .trap_lvl(trap_lvl), .tt_active(tt_active), .new_code(new_code), .blocked(blocked)
   );

   always_comb begin
      if (vec_busy)                act = ACT_HOLD;
      else if (!hit || !glb_ie)    act = ACT_CLEAR;
      else if (blocked)            act = ACT_HOLD;
      else if (new_code != irq_code) act = ACT_LOAD;
      else                         act = ACT_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req  <= 1'b0;
         irq_code <= '0;
      end else begin
         case (act)
            ACT_CLEAR: begin
               irq_req  <= 1'b0;
               irq_code <= '0;
            end
            ACT_LOAD: begin
               irq_req  <= 1'b1;
               irq_code <= new_code;
            end
            default: ;
         endcase
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !irq_req && irq_code == '0); // R1
   AST_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> irq_code[LVL_W-1:0] > $past(cur_pil)); // R4
   AST_CODE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_code & CLASS_MASK) == TRAP_BASE); // R5
   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy |=> $stable(irq_req) && $stable(irq_code)); // R6
   AST_DISABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_ie && !vec_busy |=> !irq_req && irq_code == '0); // R7
   AST_REQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (irq_code != '0)); // R10
endmodule

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [14:0] ext_lvl;
   logic [16:0] soft_reg;
   logic [3:0]  cur_pil;
   logic        glb_ie;
   logic [2:0]  trap_lvl;
   logic [8:0]  tt_active;
   logic        vec_busy;
   logic        irq_req;
   logic [8:0]  irq_code;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_level_arbiter u_irq_level_arbiter (
      .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_reg(soft_reg),
      .cur_pil(cur_pil), .glb_ie(glb_ie), .trap_lvl(trap_lvl),
      .tt_active(tt_active), .vec_busy(vec_busy),
      .irq_req(irq_req), .irq_code(irq_code)
   );

   task automatic chk(string rq, logic exp_req, logic [8:0] exp_code);
      checks++;
      if (irq_req !== exp_req || irq_code !== exp_code) begin
         errors++;
         $display("FAIL %s: req=%0b code=0x%03h expected req=%0b code=0x%03h",
                  rq, irq_req, irq_code, exp_req, exp_code);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic quiet();
      ext_lvl = '0; soft_reg = '0; cur_pil = '0; glb_ie = 1'b1;
      trap_lvl = '0; tt_active = '0; vec_busy = 1'b0;
      step();
   endtask

   task automatic t_reset();
      chk("R1 in reset", 1'b0, 9'h000);
      ext_lvl = 15'h7FFF;
      step();
      chk("R1 reset holds with inputs", 1'b0, 9'h000);
      ext_lvl = '0;
      rst_n = 1'b1;
      step();
      chk("R1 after reset", 1'b0, 9'h000);
   endtask

   task automatic t_external();
      quiet();
      ext_lvl[4] = 1'b1;             // level 5
      #1 chk("R9 no change before edge", 1'b0, 9'h000);
      step();
      chk("R2 R9 ext level 5", 1'b1, 9'h045);
   endtask

   task automatic t_soft();
      quiet();
      chk("R4 idle with nothing pending", 1'b0, 9'h000);
      soft_reg[9] = 1'b1;
      step();
      chk("R2 soft level 9", 1'b1, 9'h049);
   endtask

   task automatic t_timer();
      quiet();
      soft_reg[0] = 1'b1;
      step();
      chk("R3 timer bit 0 -> level 14", 1'b1, 9'h04E);
      soft_reg = '0; soft_reg[16] = 1'b1;
      step();
      chk("R3 timer bit 16 -> level 14", 1'b1, 9'h04E);
      soft_reg = '0; soft_reg[0] = 1'b1; cur_pil = 4'd14;
      step();
      chk("R3 timer bits give no level 0 or 15", 1'b0, 9'h000);
   endtask

   task automatic t_priority();
      quiet();
      ext_lvl[2] = 1'b1; ext_lvl[6] = 1'b1; ext_lvl[11] = 1'b1;
      step();
      chk("R5 highest of 3,7,12", 1'b1, 9'h04C);
      soft_reg[15] = 1'b1;
      step();
      chk("R5 soft 15 outranks", 1'b1, 9'h04F);
   endtask

   task automatic t_pil();
      quiet();
      ext_lvl[6] = 1'b1; cur_pil = 4'd7;
      step();
      chk("R4 level equal to pil ignored", 1'b0, 9'h000);
      cur_pil = 4'd6;
      step();
      chk("R4 level above pil", 1'b1, 9'h047);
      cur_pil = 4'd7;
      step();
      chk("R4 raise pil withdraws", 1'b0, 9'h000);
      ext_lvl = 15'h7FFF; soft_reg = 17'h1FFFF; cur_pil = 4'd15;
      step();
      chk("R4 pil 15 blocks all", 1'b0, 9'h000);
      cur_pil = 4'd3; ext_lvl = 15'h0006; soft_reg = '0; // levels 2,3
      step();
      chk("R4 only below-or-equal pending", 1'b0, 9'h000);
   endtask

   task automatic t_disable();
      quiet();
      ext_lvl[9] = 1'b1;
      step();
      chk("R7 setup level 10", 1'b1, 9'h04A);
      glb_ie = 1'b0;
      step();
      chk("R7 disable withdraws", 1'b0, 9'h000);
   endtask

   task automatic t_busy();
      quiet();
      ext_lvl[4] = 1'b1;
      step();
      chk("R6 setup level 5", 1'b1, 9'h045);
      vec_busy = 1'b1; ext_lvl = '0; ext_lvl[9] = 1'b1;
      step();
      chk("R6 busy ignores new level", 1'b1, 9'h045);
      glb_ie = 1'b0;
      step();
      chk("R6 busy ignores disable", 1'b1, 9'h045);
      glb_ie = 1'b1; vec_busy = 1'b0;
      step();
      chk("R6 release picks level 10", 1'b1, 9'h04A);
   endtask

   task automatic t_nest();
      quiet();
      ext_lvl[2] = 1'b1;
      step();
      chk("R8 setup level 3", 1'b1, 9'h043);
      ext_lvl = '0; ext_lvl[7] = 1'b1; trap_lvl = 3'd1; tt_active = 9'h04A;
      step();
      chk("R8 higher trap in service blocks", 1'b1, 9'h043);
      tt_active = 9'h047;
      step();
      chk("R8 lower trap in service allows", 1'b1, 9'h048);
      ext_lvl = '0; ext_lvl[2] = 1'b1; tt_active = 9'h000; trap_lvl = 3'd0;
      step();
      ext_lvl = '0; ext_lvl[7] = 1'b1; tt_active = 9'h04A; trap_lvl = 3'd0;
      step();
      chk("R8 trap level zero allows", 1'b1, 9'h048);
      ext_lvl = '0; ext_lvl[2] = 1'b1;
      step();
      ext_lvl = '0; ext_lvl[7] = 1'b1; trap_lvl = 3'd2; tt_active = 9'h14F;
      step();
      chk("R8 other class allows", 1'b1, 9'h048);
   endtask

   initial begin
      rst_n = 1'b0;
      ext_lvl = '0; soft_reg = '0; cur_pil = '0; glb_ie = 1'b1;
      trap_lvl = '0; tt_active = '0; vec_busy = 1'b0;
      step();
      t_reset();
      t_external();
      t_soft();
      t_timer();
      t_priority();
      t_pil();
      t_disable();
      t_busy();
      t_nest();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule